// File: doc/BRIEF.md
# Stored-Operand Dual Hex Display

This block lets a single bank of sixteen switches supply two 16-bit operands, one after the other. The operator sets the switches to the first operand and presses a load button. The block keeps that value in a register and shows it as four hexadecimal digits on the upper display group. The switches are then free for the second operand. That operand is never stored: the lower display group decodes it straight from the switches, so it tracks them continuously.

The load button is active-low, and its inverted level drives the register clock. A capture therefore happens once, at the moment the button goes down. A separate active-low button clears the stored operand at once, with no clock edge needed.

Every digit is a nibble-to-segment decoder with active-low outputs, covering all sixteen values 0 through F.

Top module: `dual_hex_display`

## Requirements
- R1: A falling edge on `load_btn_n` (a button press, seen as a rising edge of its inverted level) copies `sw[15:0]` into the stored operand.
- R2: While `rst_n_btn` is low, the stored operand is zero at once, with no press needed. A press made while reset is held stores nothing.
- R3: Capture is edge-triggered. Changing `sw` while `load_btn_n` is held low leaves the stored operand unchanged, and releasing the button (its rising edge) captures nothing.
- R4: The upper group shows the stored operand, with the most significant nibble on the left: `hex7` shows bits [15:12], `hex6` bits [11:8], `hex5` bits [7:4] and `hex4` bits [3:0].
- R5: The lower group shows the live switches, with the most significant nibble on the left: `hex3` shows `sw[15:12]`, `hex2` `sw[11:8]`, `hex1` `sw[7:4]` and `hex0` `sw[3:0]`.
- R6: Segment outputs are active-low (0 lights a segment), with segment a at bit 0 through segment g at bit 6. The patterns for nibbles 0..F, in hex, are 40 79 24 30 19 12 02 78 00 10 08 03 46 21 06 0E. Every pattern lights at least two segments.
- R7: After reset and before any capture, the upper group shows 0000 (pattern 40 on each digit) while the lower group follows the switches.
- R8: Each new press replaces the stored operand with the switch value at that press. Only the most recent capture is shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sw | input | 16 | Switch bank: the operand to capture, and the live second operand |
| rst_n_btn | input | 1 | Active-low asynchronous clear of the stored operand |
| load_btn_n | input | 1 | Active-low load button; its inverted level is the capture clock |
| hex7 | output | 7 | Upper group, leftmost digit (stored bits 15:12) |
| hex6 | output | 7 | Upper group digit (stored bits 11:8) |
| hex5 | output | 7 | Upper group digit (stored bits 7:4) |
| hex4 | output | 7 | Upper group, rightmost digit (stored bits 3:0) |
| hex3 | output | 7 | Lower group, leftmost digit (sw 15:12) |
| hex2 | output | 7 | Lower group digit (sw 11:8) |
| hex1 | output | 7 | Lower group digit (sw 7:4) |
| hex0 | output | 7 | Lower group, rightmost digit (sw 3:0) |

## Verification
The hardest case to reach from the ports is a switch change that lands while the load button is still held down. A level-sensitive store would follow that change, while an edge-triggered one must not. The stimulus presses the button and then rewrites the switches before releasing it. It checks the upper group during the hold and again after the release, while the lower group must already show the new value. A second awkward case is a press made while reset is held. It is driven by keeping the clear button low across a full press and release, then confirming that the upper group still reads zero.

// File: rtl/hexdisp_pkg.sv
package hexdisp_pkg;

    localparam int NIB_W    = 4;
    localparam int SEG_W    = 7;
    localparam int OPND_W   = 16;
    localparam int GRP_DIGS = OPND_W / NIB_W;

    typedef logic [NIB_W-1:0] nibble_t;
    typedef logic [SEG_W-1:0] seg_t;
    typedef logic [OPND_W-1:0] operand_t;

    // Active-low segment pattern for one nibble: bit 0 = a ... bit 6 = g
    function automatic seg_t nibble_pattern(input nibble_t n);
        seg_t lit;
        unique case (n)
            4'h0: lit = 7'h3F;
            4'h1: lit = 7'h06;
            4'h2: lit = 7'h5B;
            4'h3: lit = 7'h4F;
            4'h4: lit = 7'h66;
            4'h5: lit = 7'h6D;
            4'h6: lit = 7'h7D;
            4'h7: lit = 7'h07;
            4'h8: lit = 7'h7F;
            4'h9: lit = 7'h6F;
            4'hA: lit = 7'h77;
            4'hB: lit = 7'h7C;
            4'hC: lit = 7'h39;
            4'hD: lit = 7'h5E;
            4'hE: lit = 7'h79;
            4'hF: lit = 7'h71;
            default: lit = 7'h00;
        endcase
        return ~lit;
    endfunction

endpackage

// File: rtl/operand_store.sv
module operand_store #(
    parameter int WIDTH = 16
) (
    input  logic             cap_clk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] held
);
    // Edge-triggered store; the asynchronous clear wins over capture
    always_ff @(posedge cap_clk or negedge clr_n) begin
        if (!clr_n) begin
            held <= '0;
        end else begin
            held <= din;
        end
    end
endmodule

// File: rtl/nibble_seg_decoder.sv
module nibble_seg_decoder
    import hexdisp_pkg::*;
(
    input  nibble_t nib,
    output seg_t    seg_n
);
    always_comb begin
        seg_n = nibble_pattern(nib);
    end
endmodule

// File: rtl/seg_group.sv
module seg_group
    import hexdisp_pkg::*;
#(
    parameter int DIGITS = 4,
    localparam int VAL_W = DIGITS * NIB_W
) (
    input  logic [VAL_W-1:0]  value,
    output seg_t [DIGITS-1:0] segs
);
    // Digit k decodes nibble k; digit 0 is the rightmost position
    for (genvar k = 0; k < DIGITS; k++) begin : g_digit
        nibble_seg_decoder u_dec (
            .nib   (value[k*NIB_W +: NIB_W]),
            .seg_n (segs[k])
        );
    end
endmodule

// File: rtl/dual_hex_display.sv
module dual_hex_display
    import hexdisp_pkg::*;
(
    input  logic [15:0] sw,
    input  logic        rst_n_btn,
    input  logic        load_btn_n,
    output logic [6:0]  hex7,
    output logic [6:0]  hex6,
    output logic [6:0]  hex5,
    output logic [6:0]  hex4,
    output logic [6:0]  hex3,
    output logic [6:0]  hex2,
    output logic [6:0]  hex1,
    output logic [6:0]  hex0
);
    logic     load_clk;
    operand_t stored_a;
    seg_t [GRP_DIGS-1:0] upper_segs;
    seg_t [GRP_DIGS-1:0] lower_segs;

    // A press drives the button low, so the inverted level rises on press
    assign load_clk = ~load_btn_n;

    operand_store #(.WIDTH(OPND_W)) u_store (
        .cap_clk (load_clk),
        .clr_n   (rst_n_btn),
        .din     (sw),
        .held    (stored_a)
    );

    seg_group #(.DIGITS(GRP_DIGS)) u_upper (
        .value (stored_a),
        .segs  (upper_segs)
    );

    seg_group #(.DIGITS(GRP_DIGS)) u_lower (
        .value (sw),
        .segs  (lower_segs)
    );

    assign hex7 = upper_segs[3];
    assign hex6 = upper_segs[2];
    assign hex5 = upper_segs[1];
    assign hex4 = upper_segs[0];
    assign hex3 = lower_segs[3];
    assign hex2 = lower_segs[2];
    assign hex1 = lower_segs[1];
    assign hex0 = lower_segs[0];
endmodule

// File: rtl/dual_hex_display_checker.sv
module dual_hex_display_checker (
    input logic        rst_n_btn,
    input logic        load_btn_n,
    input logic [15:0] sw,
    input logic [15:0] stored_a,
    input logic [6:0]  hex7,
    input logic [6:0]  hex6,
    input logic [6:0]  hex5,
    input logic [6:0]  hex4,
    input logic [6:0]  hex3,
    input logic [6:0]  hex2,
    input logic [6:0]  hex1,
    input logic [6:0]  hex0
);
    logic press_edge;
    logic captured_since_clear;

    assign press_edge = ~load_btn_n;

    // Set once a press has happened since the last clear
    always_ff @(posedge press_edge or negedge rst_n_btn) begin
        if (!rst_n_btn) begin
            captured_since_clear <= 1'b0;
        end else begin
            captured_since_clear <= 1'b1;
        end
    end

    // At the next press the store still holds what the previous press saw,
    // whatever the switches did in between
    assert_capture_holds_R1: assert property (@(posedge press_edge) disable iff (!rst_n_btn)
        captured_since_clear |-> stored_a == $past(sw));

    // A press under reset finds the store already cleared
    assert_reset_clears_R2: assert property (@(posedge press_edge)
        !rst_n_btn |-> stored_a == 16'h0000);

    // Equal low nibbles on the two groups give equal rightmost digits
    assert_groups_agree_R4: assert property (@(posedge press_edge) disable iff (!rst_n_btn)
        (stored_a[3:0] == sw[3:0]) |-> hex4 == hex0);

    // Every legal active-low pattern lights at least two segments
    assert_pattern_lit_R6: assert property (@(posedge press_edge) disable iff (!rst_n_btn)
        ($countones(hex7) <= 5) && ($countones(hex6) <= 5) &&
        ($countones(hex5) <= 5) && ($countones(hex4) <= 5) &&
        ($countones(hex3) <= 5) && ($countones(hex2) <= 5) &&
        ($countones(hex1) <= 5) && ($countones(hex0) <= 5));
endmodule

bind dual_hex_display dual_hex_display_checker u_chk (
    .rst_n_btn  (rst_n_btn),
    .load_btn_n (load_btn_n),
    .sw         (sw),
    .stored_a   (stored_a),
    .hex7       (hex7),
    .hex6       (hex6),
    .hex5       (hex5),
    .hex4       (hex4),
    .hex3       (hex3),
    .hex2       (hex2),
    .hex1       (hex1),
    .hex0       (hex0)
);

// File: tb/dual_hex_display_test.sv
module dual_hex_display_test;
    logic        clk = 1'b0;
    logic [15:0] sw = 16'h0000;
    logic        rst_n_btn = 1'b0;
    logic        load_btn_n = 1'b1;
    logic [6:0]  hex7, hex6, hex5, hex4, hex3, hex2, hex1, hex0;
    int          n_run = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;   // 125 MHz

    dual_hex_display uut (
        .sw(sw), .rst_n_btn(rst_n_btn), .load_btn_n(load_btn_n),
        .hex7(hex7), .hex6(hex6), .hex5(hex5), .hex4(hex4),
        .hex3(hex3), .hex2(hex2), .hex1(hex1), .hex0(hex0)
    );

    // Each entry: {operand A, operand B}
    localparam logic [31:0] VECS [0:7] = '{
        32'h0123_4567, 32'h89AB_CDEF, 32'hFEDC_BA98, 32'h7654_3210,
        32'hFFFF_0000, 32'h0000_FFFF, 32'hA5A5_5A5A, 32'h1E0F_B2C3
    };

    function automatic logic [6:0] seg_exp(input logic [3:0] n);
        case (n)
            4'h0: return 7'h40;  4'h1: return 7'h79;
            4'h2: return 7'h24;  4'h3: return 7'h30;
            4'h4: return 7'h19;  4'h5: return 7'h12;
            4'h6: return 7'h02;  4'h7: return 7'h78;
            4'h8: return 7'h00;  4'h9: return 7'h10;
            4'hA: return 7'h08;  4'hB: return 7'h03;
            4'hC: return 7'h46;  4'hD: return 7'h21;
            4'hE: return 7'h06;  default: return 7'h0E;
        endcase
    endfunction

    function automatic logic [27:0] grp_exp(input logic [15:0] v);
        return {seg_exp(v[15:12]), seg_exp(v[11:8]), seg_exp(v[7:4]), seg_exp(v[3:0])};
    endfunction

    task automatic check(input string req, input logic [27:0] act, input logic [27:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic press();
        load_btn_n = 1'b0;
        tick(2);
        load_btn_n = 1'b1;
        tick(2);
    endtask

    initial begin
        tick(3);
        rst_n_btn = 1'b1;
        tick(1);
        sw = 16'h5A3C;
        tick(1);
        // R7: empty store shows zero, lower follows switches
        check("R7 upper after reset", {hex7, hex6, hex5, hex4}, grp_exp(16'h0000));
        check("R7 lower follows sw", {hex3, hex2, hex1, hex0}, grp_exp(16'h5A3C));

        // R1 R4 R5 R6 R8: vector table, each press replaces the last
        for (int i = 0; i < 8; i++) begin
            sw = VECS[i][31:16];
            tick(1);
            press();
            sw = VECS[i][15:0];
            tick(1);
            check("R4 R6 R8 upper shows A", {hex7, hex6, hex5, hex4}, grp_exp(VECS[i][31:16]));
            check("R5 R6 lower shows B", {hex3, hex2, hex1, hex0}, grp_exp(VECS[i][15:0]));
        end

        // R2: asynchronous clear, no press needed
        rst_n_btn = 1'b0;
        tick(1);
        check("R2 clear without press", {hex7, hex6, hex5, hex4}, grp_exp(16'h0000));
        // R2: press while reset is held stores nothing
        sw = 16'hBEEF;
        tick(1);
        press();
        rst_n_btn = 1'b1;
        tick(1);
        check("R2 press under reset ignored", {hex7, hex6, hex5, hex4}, grp_exp(16'h0000));

        // R3: switches change while the button is held
        sw = 16'h1234;
        tick(1);
        load_btn_n = 1'b0;
        tick(1);
        check("R1 capture on press", {hex7, hex6, hex5, hex4}, grp_exp(16'h1234));
        sw = 16'hABCD;
        tick(2);
        check("R3 held button no follow", {hex7, hex6, hex5, hex4}, grp_exp(16'h1234));
        check("R5 lower live during hold", {hex3, hex2, hex1, hex0}, grp_exp(16'hABCD));
        load_btn_n = 1'b1;
        tick(1);
        check("R3 release captures nothing", {hex7, hex6, hex5, hex4}, grp_exp(16'h1234));

        // R8: a later press replaces the value
        press();
        check("R8 latest capture wins", {hex7, hex6, hex5, hex4}, grp_exp(16'hABCD));

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule